// File: doc/BRIEF.md
# Retransmit FIFO with Half-Full Flag

This block is a first-in first-out word buffer, 512 words deep and 9 bits wide by default, with no address inputs. The writer and the reader each own an active-low strobe. A write is claimed when its strobe falls and its data is stored when the strobe rises. A read is claimed when its strobe falls. The word then sits on the output bus, with a valid qualifier, until the strobe rises. The ninth bit has no special meaning and is stored like the others.

All strobes are sampled on one clock and their edges are found inside the block. Reset is a synchronous active-low input. Three active-low flags report empty, full and more-than-half-full. A retransmit strobe moves the read pointer back to physical location zero so that stored data can be read again. If a read strobe is held low at empty, the next write flows straight through to the output. If a write strobe is held low at full, it completes as soon as a read frees a word.

Top module: `retx_fifo`

## Requirements
- R1: While reset is low and on the first clock after it is released: empty_n is 0, full_n is 1, half_n is 1 and rd_valid is 0.
- R2: Words come out in the order they were written, with all 9 bits intact, including the all-ones and all-zeros patterns.
- R3: A write whose strobe falls while full_n is 0 is dropped and never appears on the output.
- R4: The clock after a read strobe falls with empty_n at 1, rd_valid is 1 and rd_data holds the next word. rd_valid returns to 0 the clock after the read strobe rises. A read strobe that falls while empty_n is 0 leaves rd_valid at 0.
- R5: empty_n goes to 0 one clock after the fall of the read that takes the last word. empty_n goes back to 1 one clock after the rise of the next write, and not on that write's fall.
- R6: full_n goes to 0 one clock after the fall of the write that takes the 512th location. full_n goes back to 1 one clock after the next read's rise.
- R7: half_n goes to 0 one clock after the write fall that takes occupancy above 256. half_n goes back to 1 only one clock after the read rise that brings occupancy to 256 or below.
- R8: If rt_n falls after being sampled high, while wr_n and rd_n are high on that clock and the one before, then one clock later the read pointer is 0 and occupancy equals the write pointer (the words written since reset, modulo 512). All flags follow that occupancy. If rd_n or wr_n is low at the rt_n fall, the retransmit is ignored.
- R9: Suppose rd_n was lowered while empty and is still low. The first following write shows empty_n at 1 for exactly one clock after its rise. On the next clock that word is on rd_data with rd_valid at 1 and empty_n at 0. Further writes while rd_n stays low do not change rd_data.
- R10: Suppose wr_n was lowered while full and is still low. Then full_n is 1 for exactly one clock after the next read rise and returns to 0 on the clock after. The held word is stored when wr_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| rt_n | input | 1 | Active-low retransmit strobe |
| wr_data | input | 9 | Write data, taken when wr_n rises |
| rd_data | output | 9 | Read data |
| rd_valid | output | 1 | rd_data holds a read word |
| empty_n | output | 1 | Low when no word can be read |
| full_n | output | 1 | Low when no location can be claimed |
| half_n | output | 1 | Low while occupancy exceeds half the depth |

## Verification
The assertions assume that every strobe is already synchronous to clk and stays at one level for at least one sample between edges. They also assume that wr_n and rd_n are high around any retransmit pulse. The assertions that a flag holds with no opposing strobe also rely on strobes changing only at sampled levels. The bench meets these assumptions by changing every input on the falling clock edge and holding each strobe level for at least one full clock. It issues retransmit only while both other strobes have been high for several cycles, except in the one case that deliberately holds rd_n low to show the retransmit being ignored.

// File: rtl/retx_fifo.sv
module retx_fifo #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic             rt_n,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid,
  output logic             empty_n,
  output logic             full_n,
  output logic             half_n
);
  localparam int AW   = $clog2(DEPTH);
  localparam int CW   = AW + 1;
  localparam int HALF = DEPTH / 2;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    wcnt, rcnt;
  logic             w_q, r_q, rt_q;
  logic             wact, ract, wwait, rwait;

  wire w_fall  = w_q & ~wr_n;
  wire w_rise  = ~w_q & wr_n;
  wire r_fall  = r_q & ~rd_n;
  wire r_rise  = ~r_q & rd_n;
  wire wreq    = w_fall | wwait;
  wire rreq    = r_fall | rwait;
  wire wr_acc  = wreq & ~wr_n & (wcnt != CW'(DEPTH));
  wire rd_acc  = rreq & ~rd_n & (rcnt != '0);
  wire wr_cmt  = w_rise & wact;
  wire rd_done = r_rise & ract;
  wire rt_go   = rt_q & ~rt_n & rd_n & wr_n & r_q & w_q;

  assign empty_n = (rcnt != '0);
  assign full_n  = (wcnt != CW'(DEPTH));
  assign half_n  = (wcnt <= CW'(HALF));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w_q <= 1'b1; r_q <= 1'b1; rt_q <= 1'b1;
      wptr <= '0; rptr <= '0; wcnt <= '0; rcnt <= '0;
      wact <= 1'b0; ract <= 1'b0; wwait <= 1'b0; rwait <= 1'b0;
      rd_valid <= 1'b0; rd_data <= '0;
    end else begin
      w_q   <= wr_n;
      r_q   <= rd_n;
      rt_q  <= rt_n;
      wwait <= wreq & ~wr_n & ~wr_acc;
      rwait <= rreq & ~rd_n & ~rd_acc;
      if (wr_acc)      wact <= 1'b1;
      else if (wr_cmt) wact <= 1'b0;
      if (wr_cmt) wptr <= wptr + 1'b1;
      if (rd_acc) begin
        rd_data  <= mem[rptr];
        rd_valid <= 1'b1;
        ract     <= 1'b1;
      end else if (r_rise) begin
        rd_valid <= 1'b0;
        ract     <= 1'b0;
      end
      if (rt_go) begin
        rptr <= '0;
        wcnt <= {1'b0, wptr};
        rcnt <= {1'b0, wptr};
      end else begin
        if (rd_acc) rptr <= rptr + 1'b1;
        wcnt <= wcnt + CW'(wr_acc) - CW'(rd_done);
        rcnt <= rcnt + CW'(wr_cmt) - CW'(rd_acc);
      end
    end
  end

  always_ff @(posedge clk)
    if (rst_n && wr_cmt) mem[wptr] <= wr_data;

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt <= CW'(DEPTH));
  a_r2_count_order: assert property (@(posedge clk) disable iff (!rst_n)
    rcnt <= wcnt);
  a_r6_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && rd_n && r_q && rt_n) |=> !full_n);
  a_r5_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n && wr_n && w_q && rt_n) |=> !empty_n);
  a_r4_valid_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !$past(rd_n));
  a_r8_rewind_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_q && !rt_n && rd_n && wr_n && r_q && w_q) |=> (empty_n == ($past(wptr) != '0)));
endmodule

// File: tb/retx_fifo_bench.sv
module retx_fifo_bench;
  localparam int CLK_P = 10;
  localparam int DEPTH = 512;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0, wr_n = 1'b1, rd_n = 1'b1, rt_n = 1'b1;
  logic [8:0] wr_data = '0;
  logic [8:0] rd_data;
  logic       rd_valid, empty_n, full_n, half_n;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [8:0] exp_q[$];
  logic [8:0] bmem [DEPTH];
  int bw = 0;
  logic vd = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  retx_fifo u_retx_fifo (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n),
    .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
    .empty_n(empty_n), .full_n(full_n), .half_n(half_n));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid && !vd) begin
      if (exp_q.size() == 0) chk("R4", "unexpected read word", int'(rd_data), -1);
      else chk("R2", "read data order", int'(rd_data), int'(exp_q.pop_front()));
    end
    vd = rd_valid;
  end

  task automatic push(input logic [8:0] v);
    exp_q.push_back(v);
    bmem[bw % DEPTH] = v;
    bw++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; wr_n = 1; rd_n = 1; rt_n = 1;
    repeat (2) @(negedge clk);
    rst_n = 1;
    exp_q.delete();
    bw = 0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [8:0] v);
    bit room;
    @(negedge clk);
    wr_data = v; wr_n = 0;
    room = (exp_q.size() < DEPTH);
    @(negedge clk);
    wr_n = 1;
    if (room) push(v);
    @(negedge clk);
  endtask

  task automatic rd();
    @(negedge clk); rd_n = 0;
    @(negedge clk); rd_n = 1;
    @(negedge clk);
  endtask

  task automatic flags(input string req);
    chk(req, "empty_n", int'(empty_n), int'(exp_q.size() != 0));
    chk(req, "full_n",  int'(full_n),  int'(exp_q.size() != DEPTH));
    chk(req, "half_n",  int'(half_n),  int'(exp_q.size() <= DEPTH/2));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    chk("R1", "empty_n in reset", int'(empty_n), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "empty_n", int'(empty_n), 0);
    chk("R1", "full_n", int'(full_n), 1);
    chk("R1", "half_n", int'(half_n), 1);
    chk("R1", "rd_valid", int'(rd_valid), 0);

    // R4 read while empty is ignored
    @(negedge clk); rd_n = 0;
    @(negedge clk);
    chk("R4", "rd_valid on empty read", int'(rd_valid), 0);
    rd_n = 1;
    @(negedge clk);

    // R5 empty timing, R2 patterns
    @(negedge clk); wr_data = 9'h1FF; wr_n = 0;
    @(negedge clk);
    chk("R5", "empty_n after write fall", int'(empty_n), 0);
    wr_n = 1; push(9'h1FF);
    @(negedge clk);
    chk("R5", "empty_n after write rise", int'(empty_n), 1);
    wr(9'h000);
    wr(9'h0A5);
    flags("R2");
    rd(); rd();
    @(negedge clk); rd_n = 0;
    @(negedge clk);
    chk("R5", "empty_n after last read fall", int'(empty_n), 0);
    chk("R4", "rd_valid during read", int'(rd_valid), 1);
    rd_n = 1;
    @(negedge clk);
    chk("R4", "rd_valid after read rise", int'(rd_valid), 0);
    flags("R5");

    // R9 read flow-through
    @(negedge clk); rd_n = 0;
    repeat (2) @(negedge clk);
    wr_data = 9'h13C; wr_n = 0;
    @(negedge clk);
    wr_n = 1; push(9'h13C);
    @(negedge clk);
    chk("R9", "empty_n brief rise", int'(empty_n), 1);
    chk("R9", "rd_valid before flow", int'(rd_valid), 0);
    @(negedge clk);
    chk("R9", "rd_valid after flow", int'(rd_valid), 1);
    chk("R9", "rd_data flowed", int'(rd_data), 'h13C);
    chk("R9", "empty_n after flow", int'(empty_n), 0);
    wr(9'h0C3);
    chk("R9", "rd_data unchanged by 2nd write", int'(rd_data), 'h13C);
    chk("R9", "rd_valid still", int'(rd_valid), 1);
    chk("R9", "empty_n with one word", int'(empty_n), 1);
    @(negedge clk); rd_n = 1;
    @(negedge clk);
    chk("R4", "rd_valid released", int'(rd_valid), 0);
    rd();
    flags("R9");

    // R8 retransmit
    do_reset();
    for (int i = 0; i < 5; i++) wr(9'(i * 37 + 5));
    rd(); rd();
    @(negedge clk); rt_n = 0;
    @(negedge clk); rt_n = 1;
    exp_q.delete();
    for (int i = 0; i < bw; i++) exp_q.push_back(bmem[i]);
    @(negedge clk);
    flags("R8");
    for (int i = 0; i < 5; i++) rd();
    flags("R8");
    @(negedge clk); rd_n = 0;
    @(negedge clk); rt_n = 0;
    @(negedge clk); rt_n = 1;
    @(negedge clk); rd_n = 1;
    @(negedge clk);
    chk("R8", "retransmit ignored with rd_n low", int'(empty_n), 0);
    chk("R8", "no word after ignored retransmit", int'(rd_valid), 0);

    // R7 half flag, R6 full flag, R3 ignored write, R10 write flow-through
    do_reset();
    for (int i = 0; i < 256; i++) wr(9'(i ^ 'h0AA));
    flags("R7");
    @(negedge clk); wr_data = 9'h111; wr_n = 0;
    @(negedge clk);
    chk("R7", "half_n after 257th fall", int'(half_n), 0);
    wr_n = 1; push(9'h111);
    @(negedge clk);
    @(negedge clk); rd_n = 0;
    @(negedge clk);
    chk("R7", "half_n held on read fall", int'(half_n), 0);
    rd_n = 1;
    @(negedge clk);
    chk("R7", "half_n after read rise", int'(half_n), 1);
    for (int i = 0; i < 255; i++) wr(9'(i * 3 + 1));
    flags("R6");
    @(negedge clk); wr_data = 9'h0F0; wr_n = 0;
    @(negedge clk);
    chk("R6", "full_n after 512th fall", int'(full_n), 0);
    wr_n = 1; push(9'h0F0);
    @(negedge clk);
    @(negedge clk); wr_data = 9'h1EE; wr_n = 0;
    @(negedge clk);
    chk("R3", "full_n during dropped write", int'(full_n), 0);
    wr_n = 1;
    @(negedge clk);
    @(negedge clk); wr_data = 9'h1DD; wr_n = 0;
    @(negedge clk); rd_n = 0;
    @(negedge clk); rd_n = 1;
    @(negedge clk);
    chk("R10", "full_n brief rise", int'(full_n), 1);
    @(negedge clk);
    chk("R10", "full_n falls again", int'(full_n), 0);
    wr_n = 1; push(9'h1DD);
    @(negedge clk);
    flags("R6");
    for (int i = 0; i < DEPTH; i++) rd();
    chk("R3", "words left after drain", exp_q.size(), 0);
    chk("R6", "full_n after drain", int'(full_n), 1);
    chk("R5", "empty_n after drain", int'(empty_n), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule